// File: doc/BRIEF.md
# Cache Set Index Hash

This block turns a 64-bit byte address into the set number of a data cache. The policy that does the mapping is chosen at run time. The linear policy drops the line-offset bits and masks the result to the set count. The polynomial-interleave policy builds each index bit from the parity of a fixed group of address bits between bit 7 and bit 26. This spreads strided access streams across the sets. The block also raises an error flag when the configuration has no defined mapping.

The configuration inputs are a policy code, a set count and the log2 of the line size. An address is presented with `in_valid`. By default the index and the error flag come out of a register one cycle later, qualified by `out_valid`. The parameter `REG_OUT` set to 0 turns the block into a purely combinational path. Tag compare, replacement and the data arrays sit outside this block.

Top module: `cache_set_hash`

## Requirements
- R1: With policy code 0 (linear), the index is `(addr >> cfg_line_log2) & (cfg_sets - 1)`, taken to 6 bits.
- R2: Policy codes 1 (bitwise-XOR), 3 (legacy hash) and 4 (custom) all give exactly the linear index of R1, with no error.
- R3: With policy code 2 (polynomial interleave) and 32 or 64 sets, each of index bits 0 to 4 is the XOR of these address bits: bit0 {7,12,15,17,18,21,22,23,24,25}; bit1 {8,13,16,18,19,22,23,24,25,26}; bit2 {9,12,14,15,18,19,20,21,22,26}; bit3 {10,13,15,16,19,20,21,22,23}; bit4 {11,14,16,17,20,21,22,23,24}.
- R4: Under policy 2, index bit 5 equals address bit 12 when `cfg_sets` is 64, and is 0 when `cfg_sets` is 32.
- R5: Policy 2 with any set count other than 32 or 64 sets `out_err` to 1 and the index to 0.
- R6: Policy codes 5, 6 and 7 are undefined: they set `out_err` to 1 and the index to 0.
- R7: With `REG_OUT`=1, the result for an address accepted with `in_valid` appears on the outputs exactly one cycle later with `out_valid`=1, and back-to-back inputs give back-to-back results.
- R8: A cycle without `in_valid` lowers `out_valid` in the next cycle, and `out_index` and `out_err` keep their previous values.
- R9: After reset, `out_valid`, `out_index` and `out_err` are all 0.
- R10: Under policy 2, `cfg_line_log2` and the address bits outside 7 to 26 have no effect on the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Address is valid this cycle |
| in_addr | input | 64 | Byte address |
| cfg_policy | input | 3 | Policy code (0 linear, 1 bitwise-XOR, 2 polynomial, 3 legacy hash, 4 custom) |
| cfg_sets | input | 7 | Number of sets in the cache |
| cfg_line_log2 | input | 6 | log2 of the line size in bytes |
| out_valid | output | 1 | Result valid |
| out_index | output | 6 | Set index |
| out_err | output | 1 | Unsupported configuration |

## Verification
The hardest thing to reach from the ports is the full contribution of each individual address bit to each parity tree. A handful of dense addresses could hide a missing or extra tap, because two errors in the same tree cancel out. The stimulus therefore walks a single set bit through every address position from 0 to 63 under the polynomial policy, so every tap is observed on its own. It then mixes in dense patterns, changes the line-size input to prove it is ignored, and steps through the set-count and policy corners for the error flag.

// File: rtl/csh_pkg.sv
package csh_pkg;
  localparam int ADDR_W   = 64;
  localparam int IDX_W    = 6;
  localparam int SETS_W   = 7;
  localparam int LSZ_W    = 6;
  localparam int POL_W    = 3;
  localparam int HASH_TOP = 26;
  localparam int HASH_BITS = 5;

  typedef enum logic [POL_W-1:0] {
    POL_LINEAR  = 3'd0,
    POL_XORPERM = 3'd1,
    POL_POLY    = 3'd2,
    POL_LEGACY  = 3'd3,
    POL_CUSTOM  = 3'd4
  } policy_e;

  typedef struct packed {
    logic [IDX_W-1:0] index;
    logic             err;
  } idx_res_t;
endpackage

// File: rtl/csh_linear.sv
module csh_linear
  import csh_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int IW = IDX_W,
  parameter int SW = SETS_W,
  parameter int LW = LSZ_W
) (
  input  logic [AW-1:0] addr,
  input  logic [SW-1:0] sets,
  input  logic [LW-1:0] line_log2,
  output logic [IW-1:0] index
);
  logic [AW-1:0] shifted;
  logic [SW-1:0] mask_full;

  always_comb begin
    shifted   = addr >> line_log2;
    mask_full = sets - SW'(1);
    index     = shifted[IW-1:0] & mask_full[IW-1:0];
  end
endmodule

// File: rtl/csh_poly.sv
module csh_poly
  import csh_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int IW = IDX_W
) (
  input  logic [AW-1:0] addr,
  input  logic          wide,
  output logic [IW-1:0] index
);
  localparam int TW = HASH_TOP + 1;

  function automatic logic [TW-1:0] taps(input int b);
    logic [TW-1:0] m;
    m = '0;
    case (b)
      0: begin
        m[7]=1'b1; m[12]=1'b1; m[15]=1'b1; m[17]=1'b1; m[18]=1'b1;
        m[21]=1'b1; m[22]=1'b1; m[23]=1'b1; m[24]=1'b1; m[25]=1'b1;
      end
      1: begin
        m[8]=1'b1; m[13]=1'b1; m[16]=1'b1; m[18]=1'b1; m[19]=1'b1;
        m[22]=1'b1; m[23]=1'b1; m[24]=1'b1; m[25]=1'b1; m[26]=1'b1;
      end
      2: begin
        m[9]=1'b1; m[12]=1'b1; m[14]=1'b1; m[15]=1'b1; m[18]=1'b1;
        m[19]=1'b1; m[20]=1'b1; m[21]=1'b1; m[22]=1'b1; m[26]=1'b1;
      end
      3: begin
        m[10]=1'b1; m[13]=1'b1; m[15]=1'b1; m[16]=1'b1; m[19]=1'b1;
        m[20]=1'b1; m[21]=1'b1; m[22]=1'b1; m[23]=1'b1;
      end
      default: begin
        m[11]=1'b1; m[14]=1'b1; m[16]=1'b1; m[17]=1'b1; m[20]=1'b1;
        m[21]=1'b1; m[22]=1'b1; m[23]=1'b1; m[24]=1'b1;
      end
    endcase
    return m;
  endfunction

  logic [HASH_BITS-1:0] par;

  for (genvar b = 0; b < HASH_BITS; b++) begin : g_tree
    localparam logic [TW-1:0] MASK = taps(b);
    assign par[b] = ^(addr[TW-1:0] & MASK);
  end

  always_comb begin
    index = '0;
    index[HASH_BITS-1:0] = par;
    index[IW-1] = wide & addr[12];
  end
endmodule

// File: rtl/csh_select.sv
module csh_select
  import csh_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int SW = SETS_W
) (
  input  logic [POL_W-1:0] policy,
  input  logic [SW-1:0]    sets,
  input  logic [IW-1:0]    lin_index,
  input  logic [IW-1:0]    poly_index,
  output logic             wide,
  output idx_res_t         res
);
  logic sets32, sets64;

  always_comb begin
    sets32 = (sets == SW'(32));
    sets64 = (sets == SW'(64));
    wide   = sets64;
    res    = '0;
    case (policy)
      POL_LINEAR, POL_XORPERM, POL_LEGACY, POL_CUSTOM: begin
        res.index = lin_index;
      end
      POL_POLY: begin
        if (sets32 || sets64) res.index = poly_index;
        else                  res.err   = 1'b1;
      end
      default: res.err = 1'b1;
    endcase
  end

  always_comb begin
    if (!res.err && policy == POL_POLY)
      assert_poly_sets_R5: assert (sets32 || sets64);
    if (res.err)
      assert_err_zero_idx_R6: assert (res.index == '0);
  end
endmodule

// File: rtl/cache_set_hash.sv
module cache_set_hash
  import csh_pkg::*;
#(
  parameter int REG_OUT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [POL_W-1:0]  cfg_policy,
  input  logic [SETS_W-1:0] cfg_sets,
  input  logic [LSZ_W-1:0]  cfg_line_log2,
  output logic              out_valid,
  output logic [IDX_W-1:0]  out_index,
  output logic              out_err
);
  logic             rst_meta, rst_sync;
  logic [IDX_W-1:0] lin_idx, poly_idx;
  logic             wide;
  idx_res_t         comb_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  csh_linear u_lin (
    .addr(in_addr), .sets(cfg_sets), .line_log2(cfg_line_log2), .index(lin_idx)
  );

  csh_poly u_poly (
    .addr(in_addr), .wide(wide), .index(poly_idx)
  );

  csh_select u_sel (
    .policy(cfg_policy), .sets(cfg_sets), .lin_index(lin_idx),
    .poly_index(poly_idx), .wide(wide), .res(comb_res)
  );

  if (REG_OUT != 0) begin : g_reg
    logic     vld_q, vld_d;
    idx_res_t res_q, res_d;
    logic     res_en;

    always_comb begin
      res_en = in_valid;
      vld_d  = in_valid;
      res_d  = res_en ? comb_res : res_q;
    end

    always_ff @(posedge clk or negedge rst_sync) begin
      if (!rst_sync) begin
        vld_q <= 1'b0;
        res_q <= '0;
      end else begin
        vld_q <= vld_d;
        res_q <= res_d;
      end
    end

    assign out_valid = vld_q;
    assign out_index = res_q.index;
    assign out_err   = res_q.err;

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_sync)
      in_valid |=> out_valid);
    assert_idle_drops_R8: assert property (@(posedge clk) disable iff (!rst_sync)
      !in_valid |=> (!out_valid && $stable(out_index) && $stable(out_err)));
    assert_bad_policy_R6: assert property (@(posedge clk) disable iff (!rst_sync)
      (in_valid && cfg_policy > POL_CUSTOM) |=> (out_err && out_index == '0));
    assert_narrow_top_R4: assert property (@(posedge clk) disable iff (!rst_sync)
      (in_valid && cfg_policy == POL_POLY && cfg_sets == SETS_W'(32))
        |=> (!out_err && !out_index[IDX_W-1]));
    assert_wide_top_R4: assert property (@(posedge clk) disable iff (!rst_sync)
      (in_valid && cfg_policy == POL_POLY && cfg_sets == SETS_W'(64))
        |=> (out_index[IDX_W-1] == $past(in_addr[12])));
  end else begin : g_comb
    assign out_valid = in_valid;
    assign out_index = comb_res.index;
    assign out_err   = comb_res.err;
  end
endmodule

// File: tb/tb_cache_set_hash.sv
`timescale 1ns/1ps
module tb_cache_set_hash;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_addr = '0;
  logic [2:0]  cfg_policy = '0;
  logic [6:0]  cfg_sets = 7'd64;
  logic [5:0]  cfg_line_log2 = 6'd7;
  logic        out_valid;
  logic [5:0]  out_index;
  logic        out_err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cache_set_hash dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .cfg_policy(cfg_policy), .cfg_sets(cfg_sets), .cfg_line_log2(cfg_line_log2),
    .out_valid(out_valid), .out_index(out_index), .out_err(out_err)
  );

  function automatic logic [5:0] ref_lin(logic [63:0] a, logic [5:0] l, logic [6:0] s);
    logic [63:0] sh;
    logic [6:0]  m;
    sh = a >> l;
    m  = s - 7'd1;
    return sh[5:0] & m[5:0];
  endfunction

  function automatic logic [5:0] ref_poly(logic [63:0] a, bit wide);
    int t0[10] = '{7,12,15,17,18,21,22,23,24,25};
    int t1[10] = '{8,13,16,18,19,22,23,24,25,26};
    int t2[10] = '{9,12,14,15,18,19,20,21,22,26};
    int t3[9]  = '{10,13,15,16,19,20,21,22,23};
    int t4[9]  = '{11,14,16,17,20,21,22,23,24};
    logic [5:0] r;
    r = '0;
    foreach (t0[i]) r[0] ^= a[t0[i]];
    foreach (t1[i]) r[1] ^= a[t1[i]];
    foreach (t2[i]) r[2] ^= a[t2[i]];
    foreach (t3[i]) r[3] ^= a[t3[i]];
    foreach (t4[i]) r[4] ^= a[t4[i]];
    r[5] = wide ? a[12] : 1'b0;
    return r;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [63:0] a, logic [2:0] p, logic [6:0] s, logic [5:0] l);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; cfg_policy = p; cfg_sets = s; cfg_line_log2 = l;
    @(posedge clk); #1;
  endtask

  task automatic expect_res(string req, logic [5:0] idx, logic err);
    chk(req, {out_valid, out_err, out_index}, {1'b1, err, idx});
  endtask

  task automatic t_reset;
    chk("R9", {out_valid, out_err, out_index}, 8'h00);
  endtask

  task automatic t_linear;
    logic [63:0] v[4] = '{64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF,
                          64'h0000_0000_0000_1F80, 64'hDEAD_BEEF_CAFE_F00D};
    foreach (v[i]) begin
      apply(v[i], 3'd0, 7'd64, 6'd7);
      expect_res("R1", ref_lin(v[i], 6'd7, 7'd64), 1'b0);
      apply(v[i], 3'd0, 7'd16, 6'd5);
      expect_res("R1", ref_lin(v[i], 6'd5, 7'd16), 1'b0);
    end
  endtask

  task automatic t_fallback;
    logic [2:0] p[3] = '{3'd1, 3'd3, 3'd4};
    foreach (p[i]) begin
      apply(64'h0000_0ACE_1357_9BDF, p[i], 7'd32, 6'd6);
      expect_res("R2", ref_lin(64'h0000_0ACE_1357_9BDF, 6'd6, 7'd32), 1'b0);
      apply(64'h0000_0000_0000_0FC0, p[i], 7'd64, 6'd6);
      expect_res("R2", 6'h3F, 1'b0);
    end
  endtask

  task automatic t_poly_bits;
    for (int b = 0; b < 64; b++) begin
      apply(64'd1 << b, 3'd2, 7'd64, 6'd7);
      expect_res("R3", ref_poly(64'd1 << b, 1'b1), 1'b0);
    end
  endtask

  task automatic t_poly_dense;
    logic [63:0] v[4] = '{64'h0000_0000_07FF_FF80, 64'h0000_0000_0555_5500,
                          64'h1234_5678_0AAA_AA80, 64'h0000_0000_0246_8AC0};
    foreach (v[i]) begin
      apply(v[i], 3'd2, 7'd64, 6'd7);
      expect_res("R3", ref_poly(v[i], 1'b1), 1'b0);
      apply(v[i], 3'd2, 7'd32, 6'd7);
      expect_res("R4", ref_poly(v[i], 1'b0), 1'b0);
    end
  endtask

  task automatic t_poly_top;
    apply(64'h1000, 3'd2, 7'd64, 6'd7);
    expect_res("R4", ref_poly(64'h1000, 1'b1), 1'b0);
    apply(64'h1000, 3'd2, 7'd32, 6'd7);
    expect_res("R4", ref_poly(64'h1000, 1'b0), 1'b0);
  endtask

  task automatic t_poly_badsets;
    logic [6:0] s[4] = '{7'd16, 7'd1, 7'd63, 7'd33};
    foreach (s[i]) begin
      apply(64'h0000_0000_07FF_FF80, 3'd2, s[i], 6'd7);
      expect_res("R5", 6'h00, 1'b1);
    end
  endtask

  task automatic t_bad_policy;
    for (int p = 5; p < 8; p++) begin
      apply(64'h0000_0000_0000_1FC0, 3'(p), 7'd64, 6'd6);
      expect_res("R6", 6'h00, 1'b1);
    end
  endtask

  task automatic t_stream;
    @(negedge clk);
    in_valid = 1'b1; in_addr = 64'h0000_0000_0000_0140; cfg_policy = 3'd0;
    cfg_sets = 7'd64; cfg_line_log2 = 6'd6;
    @(negedge clk);
    chk("R7", {out_valid, out_err, out_index}, {2'b10, 6'd5});
    in_addr = 64'h0000_0000_0000_02C0;
    @(negedge clk);
    chk("R7", {out_valid, out_err, out_index}, {2'b10, 6'd11});
  endtask

  task automatic t_hold;
    apply(64'h0000_0000_0000_0AC0, 3'd0, 7'd64, 6'd6);
    expect_res("R8", 6'd43, 1'b0);
    @(negedge clk);
    in_valid = 1'b0; in_addr = 64'hFFFF_FFFF_FFFF_FFFF; cfg_policy = 3'd7;
    @(posedge clk); #1;
    chk("R8", {out_valid, out_err, out_index}, {2'b00, 6'd43});
    @(posedge clk); #1;
    chk("R8", {out_valid, out_err, out_index}, {2'b00, 6'd43});
  endtask

  task automatic t_line_ignored;
    logic [63:0] a = 64'hF0F0_0000_0555_AA80;
    for (int l = 0; l < 64; l += 9) begin
      apply(a, 3'd2, 7'd64, 6'(l));
      expect_res("R10", ref_poly(a, 1'b1), 1'b0);
    end
    apply(a ^ 64'hFFFF_FFFF_F800_007F, 3'd2, 7'd64, 6'd3);
    expect_res("R10", ref_poly(a, 1'b1), 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_linear();
    t_fallback();
    t_poly_bits();
    t_poly_dense();
    t_poly_top();
    t_poly_badsets();
    t_bad_policy();
    t_stream();
    t_hold();
    t_line_ignored();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule